// File: doc/BRIEF.md
# PCI Interrupt Map and Gate

This block turns level-sensitive PCI interrupt requests into a bank of interrupt-number outputs. Each request carries a device/function number, an interrupt pin index (0 to 3), a level, and a flag that says whether the device sits directly on the primary bus or behind a secondary bridge. The block derives an interrupt number from these fields. Two formulas are used, one for each kind of device. It then drives the matching output line.

The outputs are split into groups of four consecutive lines. Each group has a mapping register that software reaches over a 32-bit register bus. The top bit of the register is an enable, and it is the only bit software can change. The remaining bits hold a fixed identifier for that group. When a group's enable is clear, every request aimed at that group drives its line low. Output lines are registered and keep their level until a new request for the same number arrives.

Top module: `irq_map_gate`

## Requirements
- R1: A primary-bus request maps to number = pin + PRI_HI_OFFSET when bit 0 of the device/function number is 1, and to number = pin when that bit is 0. PRI_HI_OFFSET defaults to 16.
- R2: A request from behind a bridge (`req_behind_bridge`=1) maps to number = pin + 4 × devfn[4:3]. Each slot therefore gets four consecutive lines in 0..15.
- R3: A valid request whose group is enabled sets `irq_out[number]` to the request level on the next rising clock edge.
- R4: A valid request whose group is disabled drives `irq_out[number]` low on the next rising clock edge.
- R5: An output line holds its level until a new request for that number arrives. Clearing a group's enable does not by itself lower a line that is already high.
- R6: A request whose number is 32 or more (GROUPS × 4 or more) changes no output.
- R7: Register n is selected by address bits [5:3] with address bit 2 set. It reads as {enable, id}, where enable is bit 31 and id in bits [30:0] equals (0x1F << 6) | (n << 2).
- R8: An address with bit 2 clear reads as zero, and writes to it change no register.
- R9: A write to register n loads bit 31 of the write data into the enable. Bits [30:0] read back unchanged whatever data is written.
- R10: Reset (synchronous, active high) clears every enable and drives every output low. The id fields are unaffected.
- R11: The enable of register n gates only numbers 4n to 4n+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request strobe, one per clock |
| req_behind_bridge | input | 1 | 1 = device behind a secondary bridge, 0 = primary bus |
| req_devfn | input | 8 | Device/function number of the requester |
| req_pin | input | 2 | Interrupt pin index 0..3 |
| req_level | input | 1 | Requested interrupt level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address inside the 64-byte register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq_out | output | 32 | Interrupt number output levels |

## Verification
The bench builds the block with GROUPS=8 and PRI_HI_OFFSET=30. With this offset, odd primary device/function numbers land on lines 30 and 31 for pins 0 and 1. Pins 2 and 3 then land on 32 and 33, so the out-of-range ignore path can be reached; at the default offset of 16 no pin index can reach it. The bridge formula and the group gating are unaffected by the offset, so those checks cover the default build as well.

// File: rtl/irqmap_pkg.sv
`timescale 1ns/1ps
package irqmap_pkg;

    localparam int LINES_PER_GROUP = 4;
    localparam int PIN_W           = 2;
    localparam int DEVFN_W         = 8;
    localparam int NUM_W           = 8;
    localparam int DATA_W          = 32;
    localparam int EN_BIT          = DATA_W - 1;
    localparam int ID_W            = DATA_W - 1;
    localparam int ID_FIXED_CODE   = 'h1F;
    localparam int ID_FIXED_SHIFT  = 6;
    localparam int ID_INDEX_SHIFT  = 2;

    typedef struct packed {
        logic               behind_bridge;
        logic [DEVFN_W-1:0] devfn;
        logic [PIN_W-1:0]   pin;
        logic               level;
    } irq_req_t;

    typedef struct packed {
        logic             hit;
        logic [NUM_W-1:0] num;
        logic             level;
    } irq_route_t;

    function automatic logic [ID_W-1:0] group_id(input int idx);
        return ID_W'((ID_FIXED_CODE << ID_FIXED_SHIFT) | (idx << ID_INDEX_SHIFT));
    endfunction

endpackage

// File: rtl/irqmap_num_calc.sv
`timescale 1ns/1ps
module irqmap_num_calc
    import irqmap_pkg::*;
#(
    parameter int PRI_HI_OFFSET = 16,
    parameter int NUM_OUT       = 32
) (
    input  logic       valid,
    input  irq_req_t   req,
    output irq_route_t route
);

    logic [DEVFN_W-1:0] devfn;
    logic [NUM_W-1:0]   pri_num;
    logic [NUM_W-1:0]   sec_num;
    logic [NUM_W-1:0]   sel_num;

    assign devfn = req.devfn;

    always_comb begin
        pri_num = NUM_W'(req.pin) + (devfn[0] ? NUM_W'(PRI_HI_OFFSET) : '0);
        sec_num = NUM_W'(req.pin) + NUM_W'({devfn[4:3], 2'b00});
        sel_num = req.behind_bridge ? sec_num : pri_num;
    end

    always_comb begin
        route.num   = sel_num;
        route.level = req.level;
        route.hit   = valid && (sel_num < NUM_W'(NUM_OUT));
    end

    wire unused_devfn_bits = ^{devfn[DEVFN_W-1:5], devfn[2:1]};

endmodule

// File: rtl/irqmap_regs.sv
`timescale 1ns/1ps
module irqmap_regs
    import irqmap_pkg::*;
#(
    parameter int GROUPS = 8,
    parameter int WIN_W  = $clog2(GROUPS) + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WIN_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [GROUPS-1:0] grp_en
);

    localparam int IDX_W = $clog2(GROUPS);

    logic [IDX_W-1:0] idx;
    logic             upper;
    logic [ID_W-1:0]  id_tab [GROUPS];

    assign idx   = addr[WIN_W-1:3];
    assign upper = addr[2];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign id_tab[g] = group_id(g);

        always_ff @(posedge clk) begin
            if (rst) begin
                grp_en[g] <= 1'b0;
            end else if (wr_en && upper && (idx == IDX_W'(g))) begin
                grp_en[g] <= wdata[EN_BIT];
            end
        end
    end

    always_comb begin
        if (upper) begin
            rdata = {grp_en[idx], id_tab[idx]};
        end else begin
            rdata = '0;
        end
    end

    wire unused_reg_bits = ^{addr[1:0], wdata[EN_BIT-1:0]};

endmodule

// File: rtl/irqmap_out.sv
`timescale 1ns/1ps
module irqmap_out
    import irqmap_pkg::*;
#(
    parameter int GROUPS  = 8,
    parameter int NUM_OUT = GROUPS * LINES_PER_GROUP
) (
    input  logic               clk,
    input  logic               rst,
    input  irq_route_t         route,
    input  logic [GROUPS-1:0]  grp_en,
    output logic [NUM_OUT-1:0] irq_out
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
        localparam int GRP = i / LINES_PER_GROUP;

        always_ff @(posedge clk) begin
            if (rst) begin
                irq_out[i] <= 1'b0;
            end else if (route.hit && (route.num == NUM_W'(i))) begin
                irq_out[i] <= route.level && grp_en[GRP];
            end
        end
    end

endmodule

// File: rtl/irq_map_gate.sv
`timescale 1ns/1ps
module irq_map_gate
    import irqmap_pkg::*;
#(
    parameter  int GROUPS        = 8,
    parameter  int PRI_HI_OFFSET = 16,
    localparam int NUM_OUT       = GROUPS * LINES_PER_GROUP,
    localparam int WIN_W         = $clog2(GROUPS) + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_behind_bridge,
    input  logic [7:0]         req_devfn,
    input  logic [1:0]         req_pin,
    input  logic               req_level,
    input  logic               reg_wr_en,
    input  logic [WIN_W-1:0]   reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_OUT-1:0] irq_out
);

    irq_req_t          req;
    irq_route_t        route;
    logic [GROUPS-1:0] grp_en;

    always_comb begin
        req.behind_bridge = req_behind_bridge;
        req.devfn         = req_devfn;
        req.pin           = req_pin;
        req.level         = req_level;
    end

    irqmap_num_calc #(
        .PRI_HI_OFFSET(PRI_HI_OFFSET),
        .NUM_OUT      (NUM_OUT)
    ) u_calc (
        .valid(req_valid),
        .req  (req),
        .route(route)
    );

    irqmap_regs #(
        .GROUPS(GROUPS),
        .WIN_W (WIN_W)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .grp_en(grp_en)
    );

    irqmap_out #(
        .GROUPS (GROUPS),
        .NUM_OUT(NUM_OUT)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .route  (route),
        .grp_en (grp_en),
        .irq_out(irq_out)
    );

endmodule

// File: rtl/irqmap_chk.sv
`timescale 1ns/1ps
module irqmap_chk #(
    parameter int GROUPS = 8,
    parameter int WIN_W  = $clog2(GROUPS) + 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      req_valid,
    input logic                      req_behind_bridge,
    input logic                      req_level,
    input logic                      route_hit,
    input logic [$clog2(GROUPS*4)-1:0] line_idx,
    input logic [GROUPS-1:0]         grp_en,
    input logic [WIN_W-1:0]          reg_addr,
    input logic                      reg_wr_en,
    input logic                      wr_en_bit,
    input logic [31:0]               reg_rdata,
    input logic [GROUPS*4-1:0]       irq_out
);

    localparam int OUT_W = $clog2(GROUPS * 4);

    logic [OUT_W-3:0] grp_idx;
    assign grp_idx = line_idx[OUT_W-1:2];

    AST_BRIDGE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_behind_bridge |-> route_hit); // R2

    AST_ENABLED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        route_hit && grp_en[grp_idx] |=> irq_out[$past(line_idx)] == $past(req_level)); // R3

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
        route_hit && !grp_en[grp_idx] |=> !irq_out[$past(line_idx)]); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(irq_out)); // R5

    AST_ONE_LINE_MOVES: assert property (@(posedge clk) disable iff (rst)
        route_hit |=> $countones(irq_out ^ $past(irq_out)) <= 1); // R5

    AST_FAR_NUMBER_IGNORED: assert property (@(posedge clk) disable iff (rst)
        req_valid && !route_hit |=> $stable(irq_out)); // R6

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        reg_addr[2] && $stable(reg_addr) |-> $stable(reg_rdata[30:0])); // R7

    AST_LOWER_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_addr[2] |-> reg_rdata == 32'd0); // R8

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en && reg_addr[2] |=> ($stable(reg_addr) -> reg_rdata[31] == $past(wr_en_bit))); // R9

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0) && (grp_en == '0)); // R10

endmodule

bind irq_map_gate irqmap_chk #(
    .GROUPS(GROUPS),
    .WIN_W (WIN_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_behind_bridge(req_behind_bridge),
    .req_level        (req_level),
    .route_hit        (route.hit),
    .line_idx         (route.num[$clog2(GROUPS*4)-1:0]),
    .grp_en           (grp_en),
    .reg_addr         (reg_addr),
    .reg_wr_en        (reg_wr_en),
    .wr_en_bit        (reg_wdata[31]),
    .reg_rdata        (reg_rdata),
    .irq_out          (irq_out)
);

// File: tb/sim_irq_map_gate.sv
`timescale 1ns/1ps
module sim_irq_map_gate;

    localparam int GROUPS = 8;
    localparam int HI_OFF = 30;
    localparam int NOUT   = GROUPS * 4;
    localparam int WIN_W  = $clog2(GROUPS) + 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_behind_bridge = 1'b0;
    logic [7:0]        req_devfn = '0;
    logic [1:0]        req_pin = '0;
    logic              req_level = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [WIN_W-1:0]  reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NOUT-1:0]   irq_out;

    always #2 clk = ~clk;

    irq_map_gate #(
        .GROUPS       (GROUPS),
        .PRI_HI_OFFSET(HI_OFF)
    ) u0 (
        .clk              (clk),
        .rst              (rst),
        .req_valid        (req_valid),
        .req_behind_bridge(req_behind_bridge),
        .req_devfn        (req_devfn),
        .req_pin          (req_pin),
        .req_level        (req_level),
        .reg_wr_en        (reg_wr_en),
        .reg_addr         (reg_addr),
        .reg_wdata        (reg_wdata),
        .reg_rdata        (reg_rdata),
        .irq_out          (irq_out)
    );

    typedef struct {
        logic [NOUT-1:0] vec;
        string           tag;
    } exp_t;

    exp_t            exp_q[$];
    exp_t            cur;
    logic [NOUT-1:0] model_out = '0;
    logic [GROUPS-1:0] model_en = '0;
    int              n_cmp = 0;
    int              n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int model_num(input logic bridge, input logic [7:0] devfn, input logic [1:0] pin);
        if (bridge) return int'(pin) + int'((devfn & 8'h18) >> 1);
        return int'(pin) + (devfn[0] ? HI_OFF : 0);
    endfunction

    function automatic logic [31:0] model_read(input logic [WIN_W-1:0] a);
        int n;
        n = int'(a[WIN_W-1:3]);
        if (!a[2]) return 32'd0;
        return {model_en[n], 31'((32'h1F << 6) | (n << 2))};
    endfunction

    // driver: pushes the expected output vector for the edge that follows
    task automatic send(input logic bridge, input logic [7:0] devfn, input logic [1:0] pin,
                        input logic lvl, input string tag);
        int n;
        @(negedge clk);
        req_valid = 1'b1;
        req_behind_bridge = bridge;
        req_devfn = devfn;
        req_pin = pin;
        req_level = lvl;
        n = model_num(bridge, devfn, pin);
        if (n < NOUT) model_out[n] = model_en[n / 4] ? lvl : 1'b0;
        exp_q.push_back('{model_out, tag});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compares after each edge that consumed a request
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            check(cur.tag, irq_out, cur.vec);
        end
    end

    task automatic reg_write(input logic [WIN_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        if (a[2]) model_en[a[WIN_W-1:3]] = d[31];
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_check(input logic [WIN_W-1:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, model_read(a));
    endtask

    task automatic out_check(input string tag);
        @(negedge clk);
        check(tag, irq_out, model_out);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        model_out = '0;
        model_en = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        out_check("R10 outputs low after reset");
        for (int g = 0; g < GROUPS; g++) begin
            reg_check(WIN_W'((g << 3) | 4), "R7 id and cleared enable after reset");
            reg_check(WIN_W'(g << 3), "R8 lower word reads zero");
        end

        // R9: all ones written, only enable bit moves
        reg_write(WIN_W'(4), 32'hFFFF_FFFF);
        reg_check(WIN_W'(4), "R9 only enable bit writable");
        // R8: lower-word write does not touch register 1
        reg_write(WIN_W'(8), 32'h8000_0000);
        reg_check(WIN_W'(12), "R8 lower-word write ignored");
        reg_check(WIN_W'(8), "R8 lower word still zero");

        // R4: group 1 disabled, request lands low
        send(1'b1, 8'h08, 2'd1, 1'b1, "R4 disabled group forced low");

        for (int g = 0; g < GROUPS; g++) reg_write(WIN_W'((g << 3) | 4), 32'h8000_0000);
        reg_check(WIN_W'(28), "R9 enable reads back set");

        // R2: bridge formula over all slots
        for (int s = 0; s < 4; s++) begin
            send(1'b1, 8'((s << 3) | 8'h60), 2'(s), 1'b1, "R2 bridge slot mapping");
        end
        // R1: primary even and odd
        send(1'b0, 8'h22, 2'd2, 1'b1, "R1 primary even devfn");
        send(1'b0, 8'h05, 2'd1, 1'b1, "R1 primary odd devfn");
        send(1'b0, 8'h01, 2'd0, 1'b1, "R1 primary odd devfn pin0");
        // R6: numbers 32 and 33 ignored
        send(1'b0, 8'h03, 2'd2, 1'b1, "R6 number 32 ignored");
        send(1'b0, 8'h01, 2'd3, 1'b0, "R6 number 33 ignored");
        // R3: level follows both ways
        send(1'b0, 8'h22, 2'd2, 1'b0, "R3 level low follows");
        send(1'b0, 8'h22, 2'd2, 1'b1, "R3 level high follows");

        // R5: disabling group 1 leaves line 5 high
        send(1'b1, 8'h08, 2'd1, 1'b1, "R3 line 5 high");
        reg_write(WIN_W'(12), 32'h0000_0000);
        out_check("R5 clearing enable keeps line high");
        repeat (3) @(negedge clk);
        out_check("R5 line holds without request");
        send(1'b1, 8'h08, 2'd1, 1'b1, "R4 request after disable forced low");
        // R11: neighbouring group 2 unaffected
        send(1'b1, 8'h10, 2'd3, 1'b1, "R11 group 2 still enabled");
        send(1'b0, 8'h00, 2'd3, 1'b1, "R11 group 0 still enabled");

        // R10: reset mid-run
        do_reset();
        out_check("R10 outputs cleared by reset");
        reg_check(WIN_W'(20), "R10 enable cleared id kept");
        send(1'b1, 8'h10, 2'd0, 1'b1, "R10 enables clear after reset");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule